// File: doc/BRIEF.md
# FSK Manchester ID Demodulator

This block turns a stream of 8-bit envelope samples from a frequency-shift-keyed transponder into 44-bit identifiers. Each sample arrives with a one-cycle strobe. The block slices the sample to one bit and times the gap between rising edges, which sorts every carrier cycle into the short tone or the long tone. Runs of cycles of the same tone are folded into half-bit symbols. The symbol stream is searched for a start marker, and the pairs of symbols that follow are decoded as Manchester bits.

The block reports a frame when the next start marker arrives. At that point the accumulated identifier is presented on a 44-bit output with a single-cycle valid pulse. Two frames sent back to back therefore share one marker: it closes the first frame and opens the second. Sample strobes must be at least one idle clock apart. With that spacing, the burst of up to four symbols produced by one closed run always drains before the next run closes.

Top module: `fsk_id_demod`

## Requirements
- R1: A sample of value 127 or more slices to 1 and any smaller value slices to 0.
- R2: A carrier cycle spans from one rising edge of the sliced signal to the next. A span of at most 8 samples is the short tone (symbol value 1), and a span of 9 or more is the long tone (symbol value 0). The first rising edge after reset only synchronises the timer.
- R3: The edge-gap timer saturates at 255, so a very long low gap is always taken as the long tone and never wraps into the short tone.
- R4: A run of n equal tones yields q = (n+1)/6 symbols for the short tone and q = (n+1)/5 for the long tone, using integer division. A q of 0 or 1 emits one symbol, a q of 2, 3 or 4 emits q symbols, and a larger q emits nothing.
- R5: The six symbols 1,1,1,0,0,0 in arrival order form a start marker. A marker opens a new frame and clears the accumulated identifier.
- R6: Inside a frame, the symbol pair 1 then 0 is ID bit 0 and the pair 0 then 1 is ID bit 1. Each bit enters at the least significant end, and only the latest 44 bits are kept.
- R7: A pair of equal symbols inside a frame ends the frame and clears the identifier, so nothing is reported for it.
- R8: When a marker arrives and the accumulated identifier is nonzero, `idValid` pulses for one cycle and `idValue` shows that identifier. `idValue` holds until the next report, and an all-zero identifier is never reported.
- R9: After reset, `idValid` and `idValue` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Strobe marking a new envelope sample |
| sampleData | input | 8 | Envelope sample, unsigned |
| idValid | output | 1 | One-cycle pulse when a frame is reported |
| idValue | output | 44 | Last reported identifier |

## Verification
The bench streams back-to-back frames built from rendered carrier cycles and compares each report against the identifier it encoded. It targets these corner cases:
- Slicing at exactly 127 and 126. A slicer off by one loses every edge.
- Cycle spans of 7, 9 and 11 samples. A wrong split point breaks the tone runs and no identifier comes out.
- A 262-sample gap. A wrapping timer would call it the short tone and destroy the marker.
- A run long enough to give five symbols. Emitting those symbols would abort the frame.
- A run too short to give even one full symbol. Emitting nothing would shift the pair alignment.
- A 48-bit frame, where keeping the wrong 44 bits would show up.
- An aborted frame, which must leave no report behind. A missing clear would produce an extra pulse.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;

  // Strobes from frame control to the datapath
  typedef struct packed {
    logic winFlush;
    logic idShift;
    logic idBit;
    logic idClear;
    logic idLatch;
  } frameCtl_t;

  // Status from the datapath to frame control
  typedef struct packed {
    logic symStrobe;
    logic outValid;
    logic outSym;
    logic markHit;
    logic accNz;
    logic accLowNz;
  } frameStat_t;

  typedef enum logic [1:0] {
    F_HUNT   = 2'd0,
    F_HALF_A = 2'd1,
    F_HALF_B = 2'd2
  } frameState_t;

endpackage

// File: rtl/fsk_demod_datapath.sv
module fsk_demod_datapath
  import fsk_demod_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int THRESH    = 127,
  parameter int CNT_W     = 8,
  parameter int SPLIT_LEN = 8,
  parameter int RUN_W     = 8,
  parameter int DIV_HI    = 6,
  parameter int DIV_LO    = 5,
  parameter int MAX_SYMS  = 4,
  parameter int ID_W      = 44,
  parameter int MARK_LEN  = 6,
  parameter logic [MARK_LEN-1:0] MARKER = 6'b111000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  frameCtl_t           ctl,
  output frameStat_t          stat,
  output logic                idValid,
  output logic [ID_W-1:0]     idValue
);

  localparam int LEFT_W = $clog2(MAX_SYMS + 1);
  localparam int FILL_W = $clog2(MARK_LEN + 1);

  // ---------------- slicer and edge timer ----------------
  logic             curBit, prevBit, synced, riseEdge;
  logic             cycleStrobe, cycleFast;
  logic [CNT_W-1:0] gapCnt;

  assign curBit      = (sampleData >= SAMPLE_W'(THRESH));
  assign riseEdge    = sampleValid & curBit & ~prevBit;
  assign cycleStrobe = riseEdge & synced;
  // gapCnt holds span-1 at the closing edge
  assign cycleFast   = (gapCnt < CNT_W'(SPLIT_LEN));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBit <= 1'b1;
      synced  <= 1'b0;
      gapCnt  <= '0;
    end else if (sampleValid) begin
      prevBit <= curBit;
      if (riseEdge) begin
        gapCnt <= '0;
        synced <= 1'b1;
      end else if (gapCnt != '1) begin
        gapCnt <= gapCnt + CNT_W'(1);
      end
    end
  end

  // ---------------- run length of equal tones ----------------
  logic             runActive, runTone, runClose;
  logic [RUN_W-1:0] runLen;
  logic [RUN_W:0]   runPlus, runQuo;
  logic [LEFT_W-1:0] emitN;

  assign runClose = cycleStrobe & runActive & (cycleFast != runTone);
  assign runPlus  = {1'b0, runLen} + (RUN_W+1)'(1);
  assign runQuo   = runTone ? runPlus / (RUN_W+1)'(DIV_HI)
                            : runPlus / (RUN_W+1)'(DIV_LO);

  always_comb begin
    if (runQuo <= (RUN_W+1)'(1))             emitN = LEFT_W'(1);
    else if (runQuo <= (RUN_W+1)'(MAX_SYMS)) emitN = runQuo[LEFT_W-1:0];
    else                                     emitN = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runActive <= 1'b0;
      runTone   <= 1'b0;
      runLen    <= '0;
    end else if (cycleStrobe) begin
      if (!runActive || (cycleFast != runTone)) begin
        runActive <= 1'b1;
        runTone   <= cycleFast;
        runLen    <= RUN_W'(1);
      end else if (runLen != '1) begin
        runLen <= runLen + RUN_W'(1);
      end
    end
  end

  // ---------------- symbol emitter ----------------
  logic [LEFT_W-1:0] symLeft;
  logic              symVal, symStrobe;

  assign symStrobe = (symLeft != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      symLeft <= '0;
      symVal  <= 1'b0;
    end else if (runClose) begin
      symLeft <= emitN;
      symVal  <= runTone;
    end else if (symStrobe) begin
      symLeft <= symLeft - LEFT_W'(1);
    end
  end

  // ---------------- marker window ----------------
  logic [MARK_LEN-1:0] win, winNext;
  logic [FILL_W-1:0]   fill;
  logic                full;

  assign winNext = {win[MARK_LEN-2:0], symVal};
  assign full    = (fill == FILL_W'(MARK_LEN));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      win  <= '0;
      fill <= '0;
    end else if (ctl.winFlush) begin
      fill <= '0;
    end else if (symStrobe) begin
      win  <= winNext;
      fill <= full ? fill : fill + FILL_W'(1);
    end
  end

  // ---------------- identifier accumulator ----------------
  logic [ID_W-1:0] idAcc, idNext;

  assign idNext = ctl.idShift ? {idAcc[ID_W-2:0], ctl.idBit} : idAcc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idAcc   <= '0;
      idValue <= '0;
      idValid <= 1'b0;
    end else begin
      idAcc   <= ctl.idClear ? '0 : idNext;
      idValid <= ctl.idLatch;
      if (ctl.idLatch) idValue <= idNext;
    end
  end

  assign stat.symStrobe = symStrobe;
  assign stat.outValid  = full;
  assign stat.outSym    = win[MARK_LEN-1];
  assign stat.markHit   = symStrobe & (fill >= FILL_W'(MARK_LEN-1)) & (winNext == MARKER);
  assign stat.accNz     = |idAcc;
  assign stat.accLowNz  = |idAcc[ID_W-2:0];

endmodule

// File: rtl/fsk_demod_frame_ctl.sv
module fsk_demod_frame_ctl
  import fsk_demod_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  frameStat_t stat,
  output frameCtl_t  ctl
);

  frameState_t state, stateNext;
  logic        pendSym, pendNext;
  logic        take, nzAfter;

  assign take = stat.symStrobe & stat.outValid;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    pendNext  = pendSym;
    nzAfter   = stat.accNz;
    case (state)
      F_HALF_A: begin
        if (take) begin
          pendNext  = stat.outSym;
          stateNext = F_HALF_B;
        end
      end
      F_HALF_B: begin
        if (take) begin
          if (pendSym != stat.outSym) begin
            ctl.idShift = 1'b1;
            ctl.idBit   = stat.outSym;
            nzAfter     = stat.outSym | stat.accLowNz;
            stateNext   = F_HALF_A;
          end else begin
            ctl.idClear = 1'b1;
            nzAfter     = 1'b0;
            stateNext   = F_HUNT;
          end
        end
      end
      default: ;
    endcase
    // a marker overrides pair decoding and opens a fresh frame
    if (stat.markHit) begin
      ctl.winFlush = 1'b1;
      ctl.idClear  = 1'b1;
      ctl.idLatch  = nzAfter;
      stateNext    = F_HALF_A;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= F_HUNT;
      pendSym <= 1'b0;
    end else begin
      state   <= stateNext;
      pendSym <= pendNext;
    end
  end

endmodule

// File: rtl/fsk_id_demod.sv
module fsk_id_demod
  import fsk_demod_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int THRESH    = 127,
  parameter int CNT_W     = 8,
  parameter int SPLIT_LEN = 8,
  parameter int RUN_W     = 8,
  parameter int DIV_HI    = 6,
  parameter int DIV_LO    = 5,
  parameter int MAX_SYMS  = 4,
  parameter int ID_W      = 44
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                idValid,
  output logic [ID_W-1:0]     idValue
);

  frameStat_t stat;
  frameCtl_t  ctl;

  fsk_demod_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .THRESH   (THRESH),
    .CNT_W    (CNT_W),
    .SPLIT_LEN(SPLIT_LEN),
    .RUN_W    (RUN_W),
    .DIV_HI   (DIV_HI),
    .DIV_LO   (DIV_LO),
    .MAX_SYMS (MAX_SYMS),
    .ID_W     (ID_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .sampleData (sampleData),
    .ctl        (ctl),
    .stat       (stat),
    .idValid    (idValid),
    .idValue    (idValue)
  );

  fsk_demod_frame_ctl u_ctl (
    .clk (clk),
    .rstN(rstN),
    .stat(stat),
    .ctl (ctl)
  );

endmodule

// File: rtl/fsk_id_demod_chk.sv
module fsk_id_demod_chk #(
  parameter int ID_W = 44
) (
  input logic            clk,
  input logic            rstN,
  input logic            idValid,
  input logic [ID_W-1:0] idValue,
  input logic            markHit,
  input logic            accNz,
  input logic            outValid,
  input logic            idShift,
  input logic            idClear
);

  // R8: a report lasts exactly one cycle
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    idValid |=> !idValid);

  // R8: a zero identifier is never reported
  p_nonzero_report_r8: assert property (@(posedge clk) disable iff (!rstN)
    idValid |-> (idValue != '0));

  // R8: the output identifier only moves with a report
  p_hold_value_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(idValue) |-> idValid);

  // R5: every report is triggered by a marker one cycle earlier
  p_report_after_marker_r5: assert property (@(posedge clk) disable iff (!rstN)
    idValid |-> $past(markHit));

  // R7: a clear from control empties the accumulator
  p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    idClear |=> !accNz);

  // R6: bits are only decoded from symbols that left a full window
  p_decode_full_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    idShift |-> outValid);

endmodule

bind fsk_id_demod fsk_id_demod_chk #(.ID_W(ID_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .idValid (idValid),
  .idValue (idValue),
  .markHit (stat.markHit),
  .accNz   (stat.accNz),
  .outValid(stat.outValid),
  .idShift (ctl.idShift),
  .idClear (ctl.idClear)
);

// File: tb/fsk_id_demod_bench.sv
module fsk_id_demod_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [7:0]  sampleData = 8'd0;
  logic        idValid;
  logic [43:0] idValue;

  always #4 clk = ~clk;

  fsk_id_demod u_fsk_id_demod (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .sampleData (sampleData),
    .idValid    (idValid),
    .idValue    (idValue)
  );

  int          checks = 0;
  int          fails = 0;
  int          reports = 0;
  bit          done = 1'b0;
  bit          jitter = 1'b0;
  logic        lastValid = 1'b0;
  logic [7:0]  hiLevel = 8'd200;
  logic [7:0]  loLevel = 8'd30;
  logic [43:0] expQ[$];
  string       tagQ[$];
  logic [43:0] expVal;
  string       expTag;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // report monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN && idValid) begin
      reports++;
      check(!lastValid, "R8 single-cycle pulse", 64'(lastValid), 64'd0);
      if (expQ.size() == 0) begin
        check(1'b0, "R7 R8 unexpected report", {20'd0, idValue}, 64'd0);
      end else begin
        expVal = expQ.pop_front();
        expTag = tagQ.pop_front();
        check(idValue == expVal, expTag, {20'd0, idValue}, {20'd0, expVal});
      end
    end
    lastValid = idValid;
  end

  task automatic sendSample(input logic [7:0] v);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleData  = v;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic sendCycle(input int len, input int highN);
    for (int i = 0; i < len; i++) sendSample((i < highN) ? hiLevel : loLevel);
  endtask

  task automatic sendSym(input bit s, input int n);
    for (int k = 0; k < n; k++) begin
      if (s) sendCycle((jitter && (k % 2) != 0) ? 7 : 8, 2);
      else   sendCycle(jitter ? (((k % 2) != 0) ? 9 : 11) : 10, 3);
    end
  endtask

  task automatic sendStd(input bit s);
    sendSym(s, s ? 6 : 5);
  endtask

  task automatic sendMarker();
    sendStd(1'b1); sendStd(1'b1); sendStd(1'b1);
    sendStd(1'b0); sendStd(1'b0); sendStd(1'b0);
  endtask

  task automatic sendBits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) begin sendStd(1'b0); sendStd(1'b1); end
      else      begin sendStd(1'b1); sendStd(1'b0); end
    end
  endtask

  task automatic expectId(input logic [43:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(idValid == 1'b0, "R9 idValid after reset", 64'(idValid), 64'd0);
    check(idValue == 44'd0, "R9 idValue after reset", {20'd0, idValue}, 64'd0);
    rstN = 1'b1;

    // preamble, then frame A (first marker carries a zero ID: R8 no report)
    sendStd(1'b0);
    sendMarker();
    sendBits(64'h123456789AB, 44);
    expectId(44'h123456789AB, "R5 R6 frame A");

    // frame B: all ones
    sendMarker();
    sendBits(64'hFFFFFFFFFFF, 44);
    expectId(44'hFFFFFFFFFFF, "R6 frame B all ones");

    // frame C: 48 bits, last 44 kept
    sendMarker();
    sendBits(64'hABCDE1234567, 48);
    expectId(44'hBCDE1234567, "R6 frame C latest 44 bits");

    // frame D: slicer boundary levels
    hiLevel = 8'd127;
    loLevel = 8'd126;
    sendMarker();
    sendBits(64'h80000000001, 44);
    expectId(44'h80000000001, "R1 frame D threshold 127/126");

    // frame E: cycle spans 7/8 and 9/11
    hiLevel = 8'd200;
    loLevel = 8'd30;
    jitter  = 1'b1;
    sendMarker();
    sendBits(64'h5A5A5A5A5A5, 44);
    expectId(44'h5A5A5A5A5A5, "R2 frame E jittered spans");
    jitter  = 1'b0;

    // frame F: aborted by an equal pair, never reported
    sendMarker();
    sendBits(64'hABC, 12);
    sendStd(1'b1); sendStd(1'b1);
    sendBits(64'h3C, 8);

    // frame G: marker holds a 262-sample cycle, data followed by a five-symbol run
    sendStd(1'b1); sendStd(1'b1); sendStd(1'b1);
    for (int c = 0; c < 14; c++) sendCycle(10, 3);
    sendCycle(262, 3);
    sendBits(64'h9C300A57E1, 44);
    for (int c = 0; c < 25; c++) sendCycle(10, 3);
    expectId(44'h09C300A57E1, "R3 R4 R7 frame G saturated gap, dropped run, prior abort");

    // frame H: first symbol rendered with 4 short cycles (quotient 0)
    sendMarker();
    sendSym(1'b1, 4);
    sendStd(1'b0);
    sendBits(64'h3FF00001234, 43);
    expectId(44'h3FF00001234, "R4 frame H short run gives one symbol");

    // closing marker
    sendMarker();
    sendStd(1'b1);
    repeat (40) @(negedge clk);

    check(expQ.size() == 0, "R8 every frame reported", 64'(expQ.size()), 64'd0);
    check(reports == 7, "R7 R8 report count", 64'(reports), 64'd7);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule